// File: doc/BRIEF.md
# Test Coprocessor with Timed Interrupts

This block is a validation coprocessor that sits on a processor's coprocessor handshake and answers two configurable coprocessor numbers. It holds sixteen 32-bit general registers that both numbers can read and write. On the primary number it also takes part in memory load and store transfers, one word or a long burst, moving data between the bus and a register.

Its data-processing operations each turn a register value into a cycle count. The core can use them to stall itself for a measured time, to raise the fast or the normal interrupt request after a delay, to drop either request again, or to copy the free-running cycle count into a register as a timestamp. A test program uses these operations to place interrupts at exact points in its own instruction stream and to time its own code.

The handshake is combinational: with `cp_req` high, `cp_resp` and `cp_rdata` answer in the same cycle. Register writes, timer arming and interrupt line changes take effect at the next rising edge.

Top module: `vcp_top`

## Requirements
- R1: A register write (kind 0) in phase FIRST on either served number writes `cp_wdata` into the register selected by instruction bits 19:16 and answers DONE. A register read (kind 1) in phase FIRST drives that register on `cp_rdata` in the same cycle and answers DONE. A request carrying any other coprocessor number gets NONE (0) and changes nothing.
- R2: Memory transfers (kind 2 load, kind 3 store) are served only on the primary number. On the secondary number they answer CANT in every phase. In phase FIRST on the primary number they answer DONE and restart the beat counter.
- R3: In phase DATA, a load writes `cp_wdata` into the register selected by instruction bits 15:12, and a store drives that register on `cp_rdata`. With instruction bit 22 clear the beat answers DONE.
- R4: With instruction bit 22 set, each DATA beat answers MORE (4) while the beat counter is below 4 and then advances the counter. The beat taken with the counter at 4 answers DONE, so a long transfer is five beats. The counter restarts at every FIRST phase.
- R5: Data-processing (kind 4) takes its opcode from instruction bits 23:20 and its delay from the register selected by bits 3:0. Opcode 0 is a stall on either number. In FIRST it records finish = count + delay and answers DONE if the delay is zero, otherwise BUSY (2). In BUSY polls it answers DONE once the count has reached finish, using a wrap-safe comparison.
- R6: On the secondary number, opcode 1 drives `fiq_n` low and opcode 2 drives `irq_n` low. With a zero delay the line falls at the next edge. Otherwise it falls at the edge that ends the cycle in which `cyc_count` equals the issue count plus the delay.
- R7: Opcodes 3 and 4 drive `fiq_n` and `irq_n` high again at the next edge. They do not cancel a pending timer. A timer that fires in the same cycle wins.
- R8: Opcode 5 writes the `cyc_count` seen in its FIRST cycle into the register selected by instruction bits 3:0.
- R9: The block answers CANT (3) in these cases: any nonzero opcode on the primary number, any opcode above 5 on the secondary number, any kind code above 4, a register transfer outside phase FIRST, a data-processing request in phase DATA, and opcodes 1 to 5 in phase BUSY.
- R10: Each interrupt line has exactly one pending timer. Scheduling again with a nonzero delay replaces that line's deadline.
- R11: After reset both request lines are high, all registers read zero, and no timer is pending. While `cp_req` is low, `cp_resp` is NONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_req | input | 1 | Coprocessor request valid this cycle |
| cp_phase | input | 2 | 0 FIRST, 1 BUSY poll, 2 DATA beat |
| cp_kind | input | 3 | 0 reg write, 1 reg read, 2 load, 3 store, 4 data-processing |
| cp_num | input | 4 | Coprocessor number of the request |
| cp_instr | input | 32 | Instruction word |
| cp_wdata | input | 32 | Write data for register writes and load beats |
| cyc_count | input | 32 | Free-running cycle count |
| cp_resp | output | 3 | 0 NONE, 1 DONE, 2 BUSY, 3 CANT, 4 MORE |
| cp_rdata | output | 32 | Read data for register reads and store beats |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The bench builds the block with the default parameters: primary number 4, secondary number 5, sixteen registers and a last-beat count of 4. With these values the five-beat long burst and the number-dependent rejections can be exercised directly. The cycle count it supplies starts just below the 32-bit wrap, so the stall, timer and timestamp arithmetic runs on values that have crossed zero. The delays it uses are short enough to measure the exact edge at which each line falls, and to show that an overwritten deadline is the one that counts.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int WORD = 32;

  typedef enum logic [2:0] {
    K_REG_WR = 3'd0,
    K_REG_RD = 3'd1,
    K_MEM_LD = 3'd2,
    K_MEM_ST = 3'd3,
    K_DPROC  = 3'd4
  } vcp_kind_e;

  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_BUSY  = 2'd1,
    PH_DATA  = 2'd2
  } vcp_phase_e;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0,
    RSP_DONE = 3'd1,
    RSP_BUSY = 3'd2,
    RSP_CANT = 3'd3,
    RSP_MORE = 3'd4
  } vcp_resp_e;

  localparam logic [3:0] DP_STALL   = 4'd0;
  localparam logic [3:0] DP_FAST_AT = 4'd1;
  localparam logic [3:0] DP_NORM_AT = 4'd2;
  localparam logic [3:0] DP_FAST_OFF = 4'd3;
  localparam logic [3:0] DP_NORM_OFF = 4'd4;
  localparam logic [3:0] DP_STAMP   = 4'd5;

  // target count for a delay started at 'now'
  function automatic logic [WORD-1:0] deadline_of(input logic [WORD-1:0] now,
                                                  input logic [WORD-1:0] dly);
    return now + dly;
  endfunction

  // true once 'now' is at or past 'target' (within half the count range)
  function automatic logic reached(input logic [WORD-1:0] now,
                                   input logic [WORD-1:0] target);
    logic [WORD-1:0] diff;
    diff = now - target;
    return ~diff[WORD-1];
  endfunction
endpackage

// File: rtl/vcp_regfile.sv
module vcp_regfile #(
  parameter int NREGS = 16,
  parameter int W     = 32,
  parameter int NRD   = 3,
  parameter int IW    = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][IW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] mem_q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem_q[raddr[r]];
  end
endmodule

// File: rtl/vcp_irq_timer.sv
module vcp_irq_timer
  import vcp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WORD-1:0] cyc,
  input  logic [WORD-1:0] dly,
  input  logic            sched,
  input  logic            imm,
  input  logic            clr,
  output logic            line_n,
  output logic            pend,
  output logic            fire
);
  logic [WORD-1:0] dl_q;

  assign fire = pend && reached(cyc, dl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      dl_q   <= '0;
      line_n <= 1'b1;
    end else begin
      if (sched) begin
        pend <= 1'b1;
        dl_q <= deadline_of(cyc, dly);
      end else if (fire) begin
        pend <= 1'b0;
      end
      if (imm || fire)  line_n <= 1'b0;
      else if (clr)     line_n <= 1'b1;
    end
  end
endmodule

// File: rtl/vcp_ctrl.sv
module vcp_ctrl
  import vcp_pkg::*;
#(
  parameter int LONG_LAST = 4,
  parameter int IW        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            sel_a,
  input  logic            sel_b,
  input  logic [1:0]      phase,
  input  logic [2:0]      kind,
  input  logic [31:0]     instr,
  input  logic [WORD-1:0] wdata,
  input  logic [WORD-1:0] cyc,
  input  logic [WORD-1:0] rd_n,
  input  logic [WORD-1:0] rd_d,
  input  logic [WORD-1:0] rd_m,
  output logic [2:0]      resp,
  output logic [WORD-1:0] rdata,
  output logic            we,
  output logic [IW-1:0]   waddr,
  output logic [WORD-1:0] wd,
  output logic [1:0]      sched,
  output logic [1:0]      imm,
  output logic [1:0]      clr,
  output logic            stall_arm,
  output logic [WORD-1:0] op_dly
);
  localparam int BW = $clog2(LONG_LAST + 1) + 1;

  logic [WORD-1:0] finish_q;
  logic [BW-1:0]   beat_q;
  logic            beat_clr, beat_inc;
  logic [3:0]      op;
  logic            dp_ok, long_xfer, last_beat, dly_zero;
  logic            unused_bits;

  assign op        = instr[23:20];
  assign long_xfer = instr[22];
  assign op_dly    = rd_m;
  assign dly_zero  = (rd_m == '0);
  assign last_beat = (beat_q == BW'(LONG_LAST));
  assign dp_ok     = sel_b ? (op <= DP_STAMP) : (op == DP_STALL);
  assign unused_bits = ^{instr[31:24], instr[21:20], instr[11:4]};

  always_comb begin
    resp      = RSP_NONE;
    rdata     = '0;
    we        = 1'b0;
    waddr     = '0;
    wd        = '0;
    sched     = '0;
    imm       = '0;
    clr       = '0;
    stall_arm = 1'b0;
    beat_clr  = 1'b0;
    beat_inc  = 1'b0;
    if (req && (sel_a || sel_b)) begin
      case (kind)
        K_REG_WR: begin
          if (phase == PH_FIRST) begin
            we    = 1'b1;
            waddr = IW'(instr[19:16]);
            wd    = wdata;
            resp  = RSP_DONE;
          end else resp = RSP_CANT;
        end
        K_REG_RD: begin
          if (phase == PH_FIRST) begin
            rdata = rd_n;
            resp  = RSP_DONE;
          end else resp = RSP_CANT;
        end
        K_MEM_LD, K_MEM_ST: begin
          if (!sel_a) resp = RSP_CANT;
          else if (phase == PH_FIRST) begin
            beat_clr = 1'b1;
            resp     = RSP_DONE;
          end else if (phase == PH_DATA) begin
            if (kind == K_MEM_LD) begin
              we    = 1'b1;
              waddr = IW'(instr[15:12]);
              wd    = wdata;
            end else begin
              rdata = rd_d;
            end
            if (long_xfer && !last_beat) begin
              resp     = RSP_MORE;
              beat_inc = 1'b1;
            end else resp = RSP_DONE;
          end else resp = RSP_CANT;
        end
        K_DPROC: begin
          if (!dp_ok || phase == PH_DATA) resp = RSP_CANT;
          else if (op == DP_STALL) begin
            if (phase == PH_FIRST) begin
              stall_arm = 1'b1;
              resp      = dly_zero ? RSP_DONE : RSP_BUSY;
            end else begin
              resp = reached(cyc, finish_q) ? RSP_DONE : RSP_BUSY;
            end
          end else if (phase != PH_FIRST) resp = RSP_CANT;
          else begin
            resp = RSP_DONE;
            case (op)
              DP_FAST_AT:  if (dly_zero) imm[0] = 1'b1; else sched[0] = 1'b1;
              DP_NORM_AT:  if (dly_zero) imm[1] = 1'b1; else sched[1] = 1'b1;
              DP_FAST_OFF: clr[0] = 1'b1;
              DP_NORM_OFF: clr[1] = 1'b1;
              DP_STAMP: begin
                we    = 1'b1;
                waddr = IW'(instr[3:0]);
                wd    = cyc;
              end
              default: resp = RSP_CANT;
            endcase
          end
        end
        default: resp = RSP_CANT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      finish_q <= '0;
      beat_q   <= '0;
    end else begin
      if (stall_arm) finish_q <= deadline_of(cyc, op_dly);
      if (beat_clr)      beat_q <= '0;
      else if (beat_inc) beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/vcp_top.sv
module vcp_top
  import vcp_pkg::*;
#(
  parameter int NUM_A     = 4,
  parameter int NUM_B     = 5,
  parameter int NREGS     = 16,
  parameter int LONG_LAST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cp_req,
  input  logic [1:0]  cp_phase,
  input  logic [2:0]  cp_kind,
  input  logic [3:0]  cp_num,
  input  logic [31:0] cp_instr,
  input  logic [31:0] cp_wdata,
  input  logic [31:0] cyc_count,
  output logic [2:0]  cp_resp,
  output logic [31:0] cp_rdata,
  output logic        fiq_n,
  output logic        irq_n
);
  localparam int IW    = $clog2(NREGS);
  localparam int NRD   = 3;
  localparam int NLINE = 2;

  // named internal events, visible to the bound checker
  logic                   sel_a, sel_b;
  logic                   we;
  logic [IW-1:0]          waddr;
  logic [WORD-1:0]        wd;
  logic [NRD-1:0][IW-1:0] raddr;
  logic [NRD-1:0][WORD-1:0] rdata_rf;
  logic [NLINE-1:0]       sched, imm, clr, pend, fire, line_n;
  logic                   stall_arm;
  logic [WORD-1:0]        op_dly;

  assign sel_a = (cp_num == 4'(NUM_A));
  assign sel_b = (cp_num == 4'(NUM_B));

  assign raddr[0] = IW'(cp_instr[19:16]);
  assign raddr[1] = IW'(cp_instr[15:12]);
  assign raddr[2] = IW'(cp_instr[3:0]);

  vcp_regfile #(.NREGS(NREGS), .W(WORD), .NRD(NRD), .IW(IW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .waddr (waddr),
    .wdata (wd),
    .raddr (raddr),
    .rdata (rdata_rf)
  );

  vcp_ctrl #(.LONG_LAST(LONG_LAST), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (cp_req),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .phase     (cp_phase),
    .kind      (cp_kind),
    .instr     (cp_instr),
    .wdata     (cp_wdata),
    .cyc       (cyc_count),
    .rd_n      (rdata_rf[0]),
    .rd_d      (rdata_rf[1]),
    .rd_m      (rdata_rf[2]),
    .resp      (cp_resp),
    .rdata     (cp_rdata),
    .we        (we),
    .waddr     (waddr),
    .wd        (wd),
    .sched     (sched),
    .imm       (imm),
    .clr       (clr),
    .stall_arm (stall_arm),
    .op_dly    (op_dly)
  );

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    vcp_irq_timer u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cyc    (cyc_count),
      .dly    (op_dly),
      .sched  (sched[l]),
      .imm    (imm[l]),
      .clr    (clr[l]),
      .line_n (line_n[l]),
      .pend   (pend[l]),
      .fire   (fire[l])
    );
  end

  assign fiq_n = line_n[0];
  assign irq_n = line_n[1];
endmodule

// File: rtl/vcp_checker.sv
module vcp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cp_req,
  input logic [1:0]  cp_phase,
  input logic [2:0]  cp_kind,
  input logic        sel_a,
  input logic        sel_b,
  input logic [3:0]  cp_op,
  input logic [2:0]  cp_resp,
  input logic        fiq_n,
  input logic        irq_n,
  input logic [1:0]  fire,
  input logic [31:0] op_dly
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_req |-> cp_resp == 3'd0); // R11

  AST_RD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && (sel_a || sel_b) && cp_kind == 3'd1 && cp_phase == 2'd0
    |-> cp_resp == 3'd1); // R1

  AST_SEC_MEM_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && sel_b && !sel_a && (cp_kind == 3'd2 || cp_kind == 3'd3)
    |-> cp_resp == 3'd3); // R2

  AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && (sel_a || sel_b) && cp_kind == 3'd4 && cp_phase == 2'd0
    && cp_op == 4'd0 && op_dly == 32'd0 |-> cp_resp == 3'd1); // R5

  AST_FIRE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    fire[0] |=> !fiq_n); // R6

  AST_FIRE_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    fire[1] |=> !irq_n); // R6

  AST_CLR_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && sel_b && cp_kind == 3'd4 && cp_phase == 2'd0 && cp_op == 4'd3
    && !fire[0] |=> fiq_n); // R7

  AST_PRI_DP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req && sel_a && !sel_b && cp_kind == 3'd4 && cp_op != 4'd0
    |-> cp_resp == 3'd3); // R9
endmodule

bind vcp_top vcp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cp_req   (cp_req),
  .cp_phase (cp_phase),
  .cp_kind  (cp_kind),
  .sel_a    (sel_a),
  .sel_b    (sel_b),
  .cp_op    (cp_instr[23:20]),
  .cp_resp  (cp_resp),
  .fiq_n    (fiq_n),
  .irq_n    (irq_n),
  .fire     (fire),
  .op_dly   (op_dly)
);

// File: tb/sim_vcp_top.sv
module sim_vcp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cp_req;
  logic [1:0]  cp_phase;
  logic [2:0]  cp_kind;
  logic [3:0]  cp_num;
  logic [31:0] cp_instr, cp_wdata;
  logic [31:0] tcyc;
  logic [2:0]  cp_resp;
  logic [31:0] cp_rdata;
  logic        fiq_n, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]  g_resp;
  logic [31:0] g_rdata, g_cyc;

  localparam logic [31:0] START = 32'hFFFF_FFC0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) begin
    if (!rst_n) tcyc <= START;
    else        tcyc <= tcyc + 32'd1;
  end

  vcp_top u0 (
    .clk(clk), .rst_n(rst_n), .cp_req(cp_req), .cp_phase(cp_phase),
    .cp_kind(cp_kind), .cp_num(cp_num), .cp_instr(cp_instr),
    .cp_wdata(cp_wdata), .cyc_count(tcyc), .cp_resp(cp_resp),
    .cp_rdata(cp_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  typedef struct packed {
    logic [2:0]  k;
    logic [3:0]  n;
    logic [1:0]  ph;
    logic [31:0] ins;
    logic [31:0] wd;
    logic [2:0]  er;
    logic        chk;
    logic [31:0] erd;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 4'd4, 2'd0, 32'h0001_0000, 32'hDEAD_BEEF, 3'd1, 1'b0, 32'h0, 8'd1},         // R1
    '{3'd0, 4'd5, 2'd0, 32'h0002_0000, 32'h1234_5678, 3'd1, 1'b0, 32'h0, 8'd1},         // R1
    '{3'd1, 4'd5, 2'd0, 32'h0001_0000, 32'h0,         3'd1, 1'b1, 32'hDEAD_BEEF, 8'd1}, // R1
    '{3'd1, 4'd4, 2'd0, 32'h0002_0000, 32'h0,         3'd1, 1'b1, 32'h1234_5678, 8'd1}, // R1
    '{3'd0, 4'd6, 2'd0, 32'h0001_0000, 32'h0,         3'd0, 1'b0, 32'h0, 8'd1},         // R1
    '{3'd1, 4'd4, 2'd0, 32'h0001_0000, 32'h0,         3'd1, 1'b1, 32'hDEAD_BEEF, 8'd1}, // R1
    '{3'd0, 4'd4, 2'd1, 32'h0001_0000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd9},         // R9
    '{3'd2, 4'd5, 2'd0, 32'h0000_3000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd2},         // R2
    '{3'd3, 4'd5, 2'd2, 32'h0000_3000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd2},         // R2
    '{3'd4, 4'd4, 2'd0, 32'h0010_0000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd9},         // R9
    '{3'd4, 4'd5, 2'd0, 32'h0060_0000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd9},         // R9
    '{3'd4, 4'd5, 2'd0, 32'h0000_0000, 32'h0,         3'd1, 1'b0, 32'h0, 8'd5},         // R5
    '{3'd4, 4'd5, 2'd2, 32'h0030_0000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd9},         // R9
    '{3'd2, 4'd4, 2'd0, 32'h0000_3000, 32'h0,         3'd1, 1'b0, 32'h0, 8'd2},         // R2
    '{3'd2, 4'd4, 2'd2, 32'h0000_3000, 32'hCAFE_0003, 3'd1, 1'b0, 32'h0, 8'd3},         // R3
    '{3'd3, 4'd4, 2'd0, 32'h0000_3000, 32'h0,         3'd1, 1'b0, 32'h0, 8'd2},         // R2
    '{3'd3, 4'd4, 2'd2, 32'h0000_3000, 32'h0,         3'd1, 1'b1, 32'hCAFE_0003, 8'd3}, // R3
    '{3'd7, 4'd4, 2'd0, 32'h0000_0000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd9},         // R9
    '{3'd4, 4'd5, 2'd1, 32'h0040_0000, 32'h0,         3'd3, 1'b0, 32'h0, 8'd9}          // R9
  };

  task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic op(input logic [2:0] k, input logic [3:0] n, input logic [1:0] ph,
                    input logic [31:0] ins, input logic [31:0] wd);
    @(negedge clk);
    cp_req = 1'b1; cp_kind = k; cp_num = n; cp_phase = ph;
    cp_instr = ins; cp_wdata = wd;
    #1;
    g_resp = cp_resp; g_rdata = cp_rdata; g_cyc = tcyc;
    @(posedge clk);
    #1;
    cp_req = 1'b0;
  endtask

  task automatic watch(input int which, output logic [31:0] seen);
    seen = 32'hFFFF_FFFF;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if ((which == 0 ? fiq_n : irq_n) == 1'b0) begin
        seen = tcyc;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] t, t2, seen, c;
    int busy_n;
    rst_n = 1'b0; cp_req = 1'b0; cp_phase = '0; cp_kind = '0; cp_num = '0;
    cp_instr = '0; cp_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R11 fiq_n after reset", {31'd0, fiq_n}, 32'd1);
    check("R11 irq_n after reset", {31'd0, irq_n}, 32'd1);
    check("R11 idle resp", {29'd0, cp_resp}, 32'd0);
    op(3'd1, 4'd4, 2'd0, 32'h0005_0000, 32'h0);
    check("R11 register zero", g_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(TBL[i].k, TBL[i].n, TBL[i].ph, TBL[i].ins, TBL[i].wd);
      check($sformatf("R%0d vector %0d resp", TBL[i].rq, i), {29'd0, g_resp}, {29'd0, TBL[i].er});
      if (TBL[i].chk)
        check($sformatf("R%0d vector %0d data", TBL[i].rq, i), g_rdata, TBL[i].erd);
    end

    // R4 long load: five beats, MORE then DONE
    op(3'd2, 4'd4, 2'd0, 32'h0040_2000, 32'h0);
    check("R4 long first", {29'd0, g_resp}, 32'd1);
    for (int i = 0; i < 5; i++) begin
      op(3'd2, 4'd4, 2'd2, 32'h0040_2000, 32'd100 + 32'(i));
      check($sformatf("R4 beat %0d", i), {29'd0, g_resp}, (i < 4) ? 32'd4 : 32'd1);
    end
    op(3'd1, 4'd4, 2'd0, 32'h0002_0000, 32'h0);
    check("R4 last beat stored", g_rdata, 32'd104);
    op(3'd2, 4'd4, 2'd0, 32'h0040_2000, 32'h0);
    op(3'd2, 4'd4, 2'd2, 32'h0040_2000, 32'd200);
    check("R4 counter restarts", {29'd0, g_resp}, 32'd4);
    op(3'd3, 4'd4, 2'd0, 32'h0040_2000, 32'h0);
    op(3'd3, 4'd4, 2'd2, 32'h0040_2000, 32'h0);
    check("R4 long store beat resp", {29'd0, g_resp}, 32'd4);
    check("R3 store data", g_rdata, 32'd200);

    // R5 stall with delay 5
    op(3'd0, 4'd4, 2'd0, 32'h0007_0000, 32'd5);
    op(3'd4, 4'd4, 2'd0, 32'h0000_0007, 32'h0);
    check("R5 stall first busy", {29'd0, g_resp}, 32'd2);
    t = g_cyc; c = 32'hFFFF_FFFF; busy_n = 0;
    for (int i = 0; i < 20; i++) begin
      op(3'd4, 4'd4, 2'd1, 32'h0000_0007, 32'h0);
      if (g_resp == 3'd1) begin c = g_cyc; break; end
      busy_n++;
    end
    check("R5 stall done cycle", c, t + 32'd5);
    check("R5 stall busy polls", 32'(busy_n), 32'd4);

    // R6 delayed fast interrupt, delay 6
    op(3'd0, 4'd5, 2'd0, 32'h0003_0000, 32'd6);
    op(3'd4, 4'd5, 2'd0, 32'h0010_0003, 32'h0);
    t = g_cyc;
    check("R6 fiq not yet", {31'd0, fiq_n}, 32'd1);
    watch(0, seen);
    check("R6 fiq falls on time", seen, t + 32'd7);

    // R7 clear fast
    op(3'd4, 4'd5, 2'd0, 32'h0030_0000, 32'h0);
    check("R7 fiq cleared", {31'd0, fiq_n}, 32'd1);

    // R6 immediate normal interrupt (reg 15 is zero)
    op(3'd4, 4'd5, 2'd0, 32'h0020_000F, 32'h0);
    check("R6 irq immediate", {31'd0, irq_n}, 32'd0);
    op(3'd4, 4'd5, 2'd0, 32'h0040_0000, 32'h0);
    check("R7 irq cleared", {31'd0, irq_n}, 32'd1);

    // R7 clearing does not cancel a pending timer
    op(3'd0, 4'd5, 2'd0, 32'h0004_0000, 32'd4);
    op(3'd4, 4'd5, 2'd0, 32'h0020_0004, 32'h0);
    t = g_cyc;
    op(3'd4, 4'd5, 2'd0, 32'h0040_0000, 32'h0);
    watch(1, seen);
    check("R7 pending survives clear", seen, t + 32'd5);
    op(3'd4, 4'd5, 2'd0, 32'h0040_0000, 32'h0);

    // R10 overwrite the fast deadline: 3 then 10
    op(3'd0, 4'd5, 2'd0, 32'h0005_0000, 32'd3);
    op(3'd0, 4'd5, 2'd0, 32'h0006_0000, 32'd10);
    op(3'd4, 4'd5, 2'd0, 32'h0010_0005, 32'h0);
    op(3'd4, 4'd5, 2'd0, 32'h0010_0006, 32'h0);
    t2 = g_cyc;
    watch(0, seen);
    check("R10 newer deadline wins", seen, t2 + 32'd11);
    op(3'd4, 4'd5, 2'd0, 32'h0030_0000, 32'h0);

    // R8 timestamp
    op(3'd4, 4'd5, 2'd0, 32'h0050_0009, 32'h0);
    t = g_cyc;
    op(3'd1, 4'd5, 2'd0, 32'h0009_0000, 32'h0);
    check("R8 timestamp", g_rdata, t);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule